// File: doc/BRIEF.md
# Configuration Word Loader with Host Memory Passthrough

This block sits in front of a single-port synchronous SRAM at start-up. At first an external host owns the memory. While the host's completion input is low, the block copies every memory control, address and write-data signal from the host onto the memory pins through one register stage. This lets the host fill the SRAM with configuration words.

When the host raises its completion input, the block takes the memory for itself. It sets the memory to read mode and walks addresses 0 to 4, one per clock. The SRAM returns data one clock after it samples an address. Each returned word is loaded into its own output register: the dimension count, the particle count, the inner iteration count, the outer iteration count and the threshold. When the last word is in, the block disables the memory and pulses a one-clock completion strobe. It then holds a ready level that lets the next controller stage start. From then on it ignores the host until reset.

Top module: `cfg_loader`

## Requirements
- R1: While the loader is in passthrough and `host_done` is low at a rising edge, the outputs `mem_cen_n`, `mem_wen_n`, `mem_keep`, `mem_margin`, `mem_addr` and `mem_wdata` show the values of the matching `host_*` inputs at that edge, from that edge on.
- R2: At the edge after `host_done` is first seen high in passthrough, the memory is driven for reading: `mem_cen_n`=0 (enable is active low), `mem_wen_n`=1 (1 means read), `mem_keep`=1, `mem_margin`=0 and `mem_addr`=0. These values hold for the whole read walk.
- R3: During the read walk, `mem_addr` steps 0, 1, 2, 3, 4 with one address per clock. Address k is on the pins k clocks after the takeover edge, and address 4 is the highest address driven.
- R4: The words read from addresses 0, 1, 2, 3 and 4 land in `dim_count`, `part_count`, `inner_iters`, `outer_iters` and `thresh` in that order. Each register samples `mem_rdata` one clock after its address was on `mem_addr`, so it changes two edges after that address appeared.
- R5: `load_done` is high for exactly one clock, in the first cycle in which `thresh` holds its new value. That is six edges after the edge that saw `host_done` high.
- R6: In the cycle `load_done` rises and afterwards, `mem_cen_n`=1 and `cfg_ready`=1. Until reset, host inputs and `host_done` have no effect on the memory pins or the parameter registers.
- R7: Once the read walk has started, changes on `host_done` or any host memory input do not disturb the addresses, the captured values or the completion timing.
- R8: Synchronous active-high `rst` gives `mem_cen_n`=1, `mem_wen_n`=1, `mem_keep`=1, `mem_margin`=0, `mem_addr`=0, `mem_wdata`=0, all five parameters 0, `load_done`=0 and `cfg_ready`=0. After reset the loader is back in passthrough.
- R9: Host writes made during passthrough leave all five parameter registers at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_done | input | 1 | Host has finished filling the memory |
| host_cen_n | input | 1 | Host memory enable, active low |
| host_wen_n | input | 1 | Host write enable, active low |
| host_keep | input | 1 | Host retention control |
| host_margin | input | MARGIN_W | Host margin-adjust field |
| host_addr | input | ADDR_W | Host address |
| host_wdata | input | DATA_W | Host write data |
| mem_cen_n | output | 1 | Memory enable, active low |
| mem_wen_n | output | 1 | Memory write enable, active low |
| mem_keep | output | 1 | Memory retention control |
| mem_margin | output | MARGIN_W | Memory margin-adjust field |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid one clock after the address |
| dim_count | output | DATA_W | Word from address 0 |
| part_count | output | DATA_W | Word from address 1 |
| inner_iters | output | DATA_W | Word from address 2 |
| outer_iters | output | DATA_W | Word from address 3 |
| thresh | output | DATA_W | Word from address 4 |
| load_done | output | 1 | One-clock pulse when the last word is captured |
| cfg_ready | output | 1 | Level, high once loading is complete |

## Verification
- Passthrough values appear on the memory pins one edge after the host drives them.
- The takeover settings appear one edge after `host_done` is sampled, and address k is on the pins one edge later than that plus k.
- Parameter k changes k+2 edges after takeover. The completion pulse and the memory disable come with the fifth capture, six edges after `host_done` was sampled.
- The bench drives inputs on falling edges and samples on the falling edge after each counted rising edge. For every parameter it checks both the cycle before its capture (still zero) and the cycle of its capture. This catches any slip of one cycle in the read latency.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  // Controller phases of the loader
  typedef enum logic [1:0] {
    LD_PASS    = 2'd0,  // host owns the memory
    LD_READ    = 2'd1,  // loader walks the parameter addresses
    LD_HANDOFF = 2'd2   // loading complete, next stage may run
  } ld_state_e;

  // Number of configuration words fetched after takeover
  localparam int unsigned PARAM_WORDS = 5;

endpackage

// File: rtl/loader_seq.sv
module loader_seq
  import cfg_loader_pkg::*;
#(
  parameter int unsigned N  = PARAM_WORDS,
  parameter int unsigned SW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_done,
  output ld_state_e     state,
  output logic [SW-1:0] step,
  output logic          take_over,
  output logic          addr_adv,
  output logic [SW-1:0] next_idx,
  output logic          cap_en,
  output logic [SW-1:0] cap_idx,
  output logic          finish
);

  // Step N captures the last word; the address stops advancing at N-1
  localparam logic [SW-1:0] LAST_STEP = SW'(N);
  localparam logic [SW-1:0] LAST_ADDR = SW'(N - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= LD_PASS;
      step  <= '0;
    end else begin
      unique case (state)
        LD_PASS: begin
          if (host_done) begin
            state <= LD_READ;
            step  <= '0;
          end
        end
        LD_READ: begin
          if (step == LAST_STEP) begin
            state <= LD_HANDOFF;
            step  <= '0;
          end else begin
            step <= step + SW'(1);
          end
        end
        default: begin
          state <= LD_HANDOFF;
        end
      endcase
    end
  end

  always_comb begin
    take_over = (state == LD_PASS) && host_done;
    addr_adv  = (state == LD_READ) && (step < LAST_ADDR);
    next_idx  = step + SW'(1);
    cap_en    = (state == LD_READ) && (step != '0);
    cap_idx   = step - SW'(1);
    finish    = (state == LD_READ) && (step == LAST_STEP);
  end

endmodule

// File: rtl/mem_port_mux.sv
module mem_port_mux
  import cfg_loader_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned MARGIN_W = 3,
  parameter int unsigned SW       = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  ld_state_e           state,
  input  logic                take_over,
  input  logic                addr_adv,
  input  logic [SW-1:0]       next_idx,
  input  logic                finish,
  input  logic                host_cen_n,
  input  logic                host_wen_n,
  input  logic                host_keep,
  input  logic [MARGIN_W-1:0] host_margin,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [DATA_W-1:0]   host_wdata,
  output logic                mem_cen_n,
  output logic                mem_wen_n,
  output logic                mem_keep,
  output logic [MARGIN_W-1:0] mem_margin,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_cen_n  <= 1'b1;
      mem_wen_n  <= 1'b1;
      mem_keep   <= 1'b1;
      mem_margin <= '0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else if (take_over) begin
      // loader claims the memory: enabled, read mode, default margin
      mem_cen_n  <= 1'b0;
      mem_wen_n  <= 1'b1;
      mem_keep   <= 1'b1;
      mem_margin <= '0;
      mem_addr   <= '0;
    end else if (state == LD_PASS) begin
      mem_cen_n  <= host_cen_n;
      mem_wen_n  <= host_wen_n;
      mem_keep   <= host_keep;
      mem_margin <= host_margin;
      mem_addr   <= host_addr;
      mem_wdata  <= host_wdata;
    end else if (state == LD_READ) begin
      mem_wen_n  <= 1'b1;
      mem_keep   <= 1'b1;
      mem_margin <= '0;
      if (addr_adv) begin
        mem_addr <= ADDR_W'(next_idx);
      end
      mem_cen_n <= finish;
    end
  end

endmodule

// File: rtl/param_bank.sv
module param_bank #(
  parameter int unsigned N      = 5,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IW     = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cap_en,
  input  logic [IW-1:0]             cap_idx,
  input  logic [DATA_W-1:0]         rdata,
  output logic [N-1:0][DATA_W-1:0]  words
);

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        words[g] <= '0;
      end else if (cap_en && (cap_idx == IW'(g))) begin
        words[g] <= rdata;
      end
    end
  end

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned MARGIN_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_done,
  input  logic                host_cen_n,
  input  logic                host_wen_n,
  input  logic                host_keep,
  input  logic [MARGIN_W-1:0] host_margin,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [DATA_W-1:0]   host_wdata,
  output logic                mem_cen_n,
  output logic                mem_wen_n,
  output logic                mem_keep,
  output logic [MARGIN_W-1:0] mem_margin,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [DATA_W-1:0]   dim_count,
  output logic [DATA_W-1:0]   part_count,
  output logic [DATA_W-1:0]   inner_iters,
  output logic [DATA_W-1:0]   outer_iters,
  output logic [DATA_W-1:0]   thresh,
  output logic                load_done,
  output logic                cfg_ready
);

  localparam int unsigned N  = PARAM_WORDS;
  localparam int unsigned SW = $clog2(N + 1);

  ld_state_e            seq_state;
  logic [SW-1:0]        seq_step;
  logic                 take_over;
  logic                 addr_adv;
  logic [SW-1:0]        next_idx;
  logic                 cap_en;
  logic [SW-1:0]        cap_idx;
  logic                 finish;
  logic [N-1:0][DATA_W-1:0] words;

  loader_seq #(.N(N), .SW(SW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .host_done (host_done),
    .state     (seq_state),
    .step      (seq_step),
    .take_over (take_over),
    .addr_adv  (addr_adv),
    .next_idx  (next_idx),
    .cap_en    (cap_en),
    .cap_idx   (cap_idx),
    .finish    (finish)
  );

  mem_port_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MARGIN_W(MARGIN_W), .SW(SW)
  ) u_mux (
    .clk         (clk),
    .rst         (rst),
    .state       (seq_state),
    .take_over   (take_over),
    .addr_adv    (addr_adv),
    .next_idx    (next_idx),
    .finish      (finish),
    .host_cen_n  (host_cen_n),
    .host_wen_n  (host_wen_n),
    .host_keep   (host_keep),
    .host_margin (host_margin),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .mem_cen_n   (mem_cen_n),
    .mem_wen_n   (mem_wen_n),
    .mem_keep    (mem_keep),
    .mem_margin  (mem_margin),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata)
  );

  param_bank #(.N(N), .DATA_W(DATA_W), .IW(SW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .cap_en  (cap_en),
    .cap_idx (cap_idx),
    .rdata   (mem_rdata),
    .words   (words)
  );

  // word order: 0 dimensions, 1 particles, 2 inner, 3 outer, 4 threshold
  assign dim_count   = words[0];
  assign part_count  = words[1];
  assign inner_iters = words[2];
  assign outer_iters = words[3];
  assign thresh      = words[4];

  always_ff @(posedge clk) begin
    if (rst) begin
      load_done <= 1'b0;
    end else begin
      load_done <= finish;
    end
  end

  assign cfg_ready = (seq_state == LD_HANDOFF);

  logic unused_step;
  assign unused_step = ^seq_step;

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk
  import cfg_loader_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned MARGIN_W = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                host_done,
  input logic                host_cen_n,
  input logic                host_wen_n,
  input logic                host_keep,
  input logic [MARGIN_W-1:0] host_margin,
  input logic [ADDR_W-1:0]   host_addr,
  input logic [DATA_W-1:0]   host_wdata,
  input logic                mem_cen_n,
  input logic                mem_wen_n,
  input logic                mem_keep,
  input logic [MARGIN_W-1:0] mem_margin,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [DATA_W-1:0]   mem_wdata,
  input logic                load_done,
  input logic                cfg_ready,
  input ld_state_e           seq_state
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(PARAM_WORDS - 1);

  a_r1_pass_forward: assert property (@(posedge clk) disable iff (rst)
    (seq_state == LD_PASS && !host_done) |=>
      (mem_cen_n == $past(host_cen_n) && mem_wen_n == $past(host_wen_n) &&
       mem_keep == $past(host_keep) && mem_margin == $past(host_margin) &&
       mem_addr == $past(host_addr) && mem_wdata == $past(host_wdata)));

  a_r2_takeover: assert property (@(posedge clk) disable iff (rst)
    (seq_state == LD_PASS && host_done) |=>
      (!mem_cen_n && mem_wen_n && mem_keep && mem_margin == '0 &&
       mem_addr == '0));

  a_r2_read_mode: assert property (@(posedge clk) disable iff (rst)
    (seq_state == LD_READ) |->
      (!mem_cen_n && mem_wen_n && mem_keep && mem_margin == '0));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (seq_state == LD_READ && mem_addr < TOP_ADDR) |=>
      (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  a_r3_addr_bound: assert property (@(posedge clk) disable iff (rst)
    (seq_state == LD_READ) |-> (mem_addr <= TOP_ADDR));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    load_done |=> !load_done);

  a_r6_done_disables: assert property (@(posedge clk) disable iff (rst)
    load_done |-> (cfg_ready && mem_cen_n));

  a_r6_handoff_hold: assert property (@(posedge clk) disable iff (rst)
    cfg_ready |=> (cfg_ready && mem_cen_n && $stable(mem_addr) &&
                   $stable(mem_wen_n)));

endmodule

bind cfg_loader cfg_loader_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MARGIN_W(MARGIN_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_done   (host_done),
  .host_cen_n  (host_cen_n),
  .host_wen_n  (host_wen_n),
  .host_keep   (host_keep),
  .host_margin (host_margin),
  .host_addr   (host_addr),
  .host_wdata  (host_wdata),
  .mem_cen_n   (mem_cen_n),
  .mem_wen_n   (mem_wen_n),
  .mem_keep    (mem_keep),
  .mem_margin  (mem_margin),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .load_done   (load_done),
  .cfg_ready   (cfg_ready),
  .seq_state   (seq_state)
);

// File: tb/cfg_loader_test.sv
`timescale 1ns/1ps
module cfg_loader_test;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int MW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          host_done;
  logic          host_cen_n, host_wen_n, host_keep;
  logic [MW-1:0] host_margin;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_wdata;
  logic          mem_cen_n, mem_wen_n, mem_keep;
  logic [MW-1:0] mem_margin;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] dim_count, part_count, inner_iters, outer_iters, thresh;
  logic          load_done, cfg_ready;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cfg_loader #(.ADDR_W(AW), .DATA_W(DW), .MARGIN_W(MW)) uut (
    .clk(clk), .rst(rst), .host_done(host_done),
    .host_cen_n(host_cen_n), .host_wen_n(host_wen_n), .host_keep(host_keep),
    .host_margin(host_margin), .host_addr(host_addr), .host_wdata(host_wdata),
    .mem_cen_n(mem_cen_n), .mem_wen_n(mem_wen_n), .mem_keep(mem_keep),
    .mem_margin(mem_margin), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .dim_count(dim_count), .part_count(part_count), .inner_iters(inner_iters),
    .outer_iters(outer_iters), .thresh(thresh),
    .load_done(load_done), .cfg_ready(cfg_ready)
  );

  // behavioural single-port synchronous SRAM, one-clock read latency
  logic [DW-1:0] sram [256];
  always @(posedge clk) begin
    if (!mem_cen_n) begin
      if (!mem_wen_n) sram[mem_addr] <= mem_wdata;
      else            mem_rdata      <= sram[mem_addr];
    end
  end

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] param_at(input int k);
    case (k)
      0: return dim_count;
      1: return part_count;
      2: return inner_iters;
      3: return outer_iters;
      default: return thresh;
    endcase
  endfunction

  task automatic host_idle();
    host_cen_n = 1'b1; host_wen_n = 1'b1; host_keep = 1'b1;
    host_margin = '0; host_addr = '0; host_wdata = '0;
  endtask

  task automatic t_reset();
    rst = 1'b1; host_done = 1'b0; host_idle();
    repeat (3) @(negedge clk);
    check("R8 cen_n", 32'(mem_cen_n), 1);
    check("R8 wen_n", 32'(mem_wen_n), 1);
    check("R8 keep", 32'(mem_keep), 1);
    check("R8 margin", 32'(mem_margin), 0);
    check("R8 addr", 32'(mem_addr), 0);
    check("R8 wdata", 32'(mem_wdata), 0);
    for (int k = 0; k < 5; k++) check("R8 param", 32'(param_at(k)), 0);
    check("R8 load_done", 32'(load_done), 0);
    check("R8 cfg_ready", 32'(cfg_ready), 0);
    rst = 1'b0;
  endtask

  // drive one host access, check it on the pins one edge later (R1)
  task automatic host_drive(input logic cen, input logic wen, input logic keep,
                            input logic [MW-1:0] mg, input logic [AW-1:0] a,
                            input logic [DW-1:0] d);
    host_cen_n = cen; host_wen_n = wen; host_keep = keep;
    host_margin = mg; host_addr = a; host_wdata = d;
    @(negedge clk);
    check("R1 cen_n", 32'(mem_cen_n), 32'(cen));
    check("R1 wen_n", 32'(mem_wen_n), 32'(wen));
    check("R1 keep", 32'(mem_keep), 32'(keep));
    check("R1 margin", 32'(mem_margin), 32'(mg));
    check("R1 addr", 32'(mem_addr), 32'(a));
    check("R1 wdata", 32'(mem_wdata), 32'(d));
  endtask

  task automatic t_fill(input logic [DW-1:0] w [5]);
    host_drive(1'b1, 1'b1, 1'b0, 3'd7, 8'hff, 16'h1234);  // idle, odd fields
    for (int k = 0; k < 5; k++)
      host_drive(1'b0, 1'b0, k[0], MW'(k), AW'(k), w[k]);
    host_drive(1'b0, 1'b0, 1'b1, 3'd2, 8'd5, 16'hdead);   // decoy word
    host_idle();
    @(negedge clk);
    for (int k = 0; k < 5; k++) check("R9 param untouched", 32'(param_at(k)), 0);
    check("R9 ready low", 32'(cfg_ready), 0);
  endtask

  task automatic t_load(input logic [DW-1:0] w [5], input bit disturb);
    host_done = 1'b1;
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk);
      if (disturb) begin
        host_done = c[0];
        host_cen_n = 1'b0; host_wen_n = 1'b0; host_keep = 1'b0;
        host_margin = 3'd5; host_addr = 8'hc0 + AW'(c); host_wdata = 16'hbeef;
      end
      if (c == 1) begin
        check("R2 wen_n", 32'(mem_wen_n), 1);
        check("R2 keep", 32'(mem_keep), 1);
        check("R2 margin", 32'(mem_margin), 0);
      end
      if (c <= 5) check(disturb ? "R7 addr" : "R3 addr", 32'(mem_addr), c - 1);
      if (c <= 6) check("R2 cen_n low", 32'(mem_cen_n), 0);
      for (int k = 0; k < 5; k++) begin
        if (c == k + 2) check("R4 before capture", 32'(param_at(k)), 0);
        if (c == k + 3)
          check(disturb ? "R7 capture" : "R4 capture", 32'(param_at(k)), 32'(w[k]));
      end
      check("R5 load_done", 32'(load_done), (c == 7) ? 1 : 0);
      check("R6 cfg_ready", 32'(cfg_ready), (c >= 7) ? 1 : 0);
      if (c >= 7) check("R6 cen_n high", 32'(mem_cen_n), 1);
    end
    host_done = 1'b0; host_idle();
  endtask

  task automatic t_after(input logic [DW-1:0] w [5]);
    for (int c = 0; c < 4; c++) begin
      host_done = c[0]; host_cen_n = 1'b0; host_wen_n = 1'b0;
      host_margin = 3'd6; host_addr = '0; host_wdata = 16'h0bad;
      @(negedge clk);
      check("R6 cen_n held", 32'(mem_cen_n), 1);
      check("R6 addr held", 32'(mem_addr), 4);
      check("R6 wen_n held", 32'(mem_wen_n), 1);
      check("R6 ready held", 32'(cfg_ready), 1);
      for (int k = 0; k < 5; k++) check("R6 param held", 32'(param_at(k)), 32'(w[k]));
    end
    host_done = 1'b0; host_idle();
    check("R6 sram word0 kept", 32'(sram[0]), 32'(w[0]));
  endtask

  initial begin
    logic [DW-1:0] set_a [5];
    logic [DW-1:0] set_b [5];
    set_a = '{16'h0003, 16'h0040, 16'h0011, 16'h0200, 16'h7fff};
    set_b = '{16'hffff, 16'h8001, 16'h0000, 16'h5a5a, 16'ha5a5};
    t_reset();
    t_fill(set_a);
    t_load(set_a, 1'b0);
    t_after(set_a);
    t_reset();          // R8: back to passthrough, params cleared
    t_fill(set_b);
    t_load(set_b, 1'b1);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule